// File: doc/BRIEF.md
# Programmable Interlaced Display Timing Generator

This block produces the raster timing for a video display output. A pixel counter runs across each line and a line counter runs down the frame. Both wrap at end values given on input ports. Horizontal blanking and horizontal sync are decoded from pixel-count compares. Vertical blanking, vertical sync and the field indicator are decoded from (line, pixel) positions, with one pair per field. An interlaced raster can therefore change field, or start or end vertical blanking, in the middle of a line.

The current pixel and line counts come out as position status. Three sticky flags report a finished field 1, a finished field 2 and a finished frame. Each flag is cleared by its own clear bit. All timing outputs are registered, so each one changes one clock after the counter value that triggers it. A low enable, or a frame size of zero in both dimensions, holds the generator idle.

Top module: `disp_raster_gen`

## Requirements
- R1: After reset, `x_pos`, `y_pos`, `hblank`, `hsync`, `vblank`, `vsync`, `field` and the three done flags are all 0. A field value of 0 means field 1 and 1 means field 2.
- R2: While running, `x_pos` counts up by one each clock. In the clock after `x_pos` reaches or exceeds `px_last`, it returns to 0 and `y_pos` advances. `y_pos` returns to 0 after a line that ends with `y_pos` at or above `ln_last`.
- R3: `hblank` goes high in the clock after `x_pos` equals `hb_on` and goes low in the clock after `x_pos` equals `hb_off`. When both compares hit in the same clock, the output goes low, so equal values keep it low.
- R4: `hsync` follows the same rule using `hs_on` and `hs_off`.
- R5: `vblank` goes high in the clock after (`y_pos`, `x_pos`) equals either field's start pair (`vb_on_y[i]`, `vb_on_x[i]`, i=0 for field 1 and i=1 for field 2). It goes low in the clock after either field's end pair matches. The end match wins.
- R6: `vsync` follows the R5 rule using the `vs_on_*` and `vs_off_*` pairs.
- R7: `field` becomes 1 in the clock after the position reaches the field-2 pair (`fld_y[1]`, `fld_x[1]`). It becomes 0 in the clock after the position reaches the field-1 pair (index 0). If both pairs match at once, the field-1 pair wins.
- R8: `f1_done` is set in the clock after the field-2 pair is reached while `field` is 0. `f2_done` and `frm_done` are set together in the clock after the field-1 pair is reached while `field` is 1. All three stay set until cleared.
- R9: Bits 0, 1 and 2 of `done_clr` clear `f1_done`, `f2_done` and `frm_done` on the next clock. A set in the same clock wins over a clear.
- R10: While `en` is low, both counters go to 0 on the next clock. `hblank`, `hsync`, `vblank`, `vsync` and `field` go to 0, and the done flags keep their values.
- R11: With `px_last` and `ln_last` both 0, the generator behaves as in R10: the counters stay at 0 and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| px_last | input | CW | Last pixel index of a line |
| ln_last | input | CW | Last line index of a frame |
| hb_on | input | CW | Pixel where horizontal blanking starts |
| hb_off | input | CW | Pixel where horizontal blanking ends |
| hs_on | input | CW | Pixel where horizontal sync starts |
| hs_off | input | CW | Pixel where horizontal sync ends |
| vb_on_x | input | 2xCW | Vertical blanking start pixel, per field |
| vb_on_y | input | 2xCW | Vertical blanking start line, per field |
| vb_off_x | input | 2xCW | Vertical blanking end pixel, per field |
| vb_off_y | input | 2xCW | Vertical blanking end line, per field |
| vs_on_x | input | 2xCW | Vertical sync start pixel, per field |
| vs_on_y | input | 2xCW | Vertical sync start line, per field |
| vs_off_x | input | 2xCW | Vertical sync end pixel, per field |
| vs_off_y | input | 2xCW | Vertical sync end line, per field |
| fld_x | input | 2xCW | Pixel where each field begins |
| fld_y | input | 2xCW | Line where each field begins |
| done_clr | input | 3 | Clear bits for f1/f2/frame done |
| x_pos | output | CW | Current pixel count |
| y_pos | output | CW | Current line count |
| hblank | output | 1 | Horizontal blanking |
| hsync | output | 1 | Horizontal sync |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| field | output | 1 | Current field, 0 = field 1 |
| f1_done | output | 1 | Sticky field-1 complete |
| f2_done | output | 1 | Sticky field-2 complete |
| frm_done | output | 1 | Sticky frame complete |

## Verification
The bench places vertical edges and the field change in the middle of a line. A design that compared only the line count would move those edges to pixel 0, and the per-cycle comparison would show the difference. Start and end values that are equal must keep an output low. A design that let the start win would hold that output high for a whole line or frame. The bench also runs through the first frame after reset, where the field-1 position is met while already in field 1; a design that flagged completion on any field-position hit would raise the field-2 and frame done flags early. It also covers a clear bit applied to a single flag, an enable drop in mid-frame that must leave the done flags untouched, and a zero frame size that must leave the counters at zero with every output quiet.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;
  localparam int NFIELD = 2;
  localparam int FLD_ONE = 0;
  localparam int FLD_TWO = 1;
  localparam int DONE_W = 3;
  localparam int DONE_F1 = 0;
  localparam int DONE_F2 = 1;
  localparam int DONE_FRM = 2;
endpackage

// File: rtl/tg_counters.sv
module tg_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] px_last,
  input  logic [CW-1:0] ln_last,
  output logic          run,
  output logic [CW-1:0] px,
  output logic [CW-1:0] ln
);
  logic [CW-1:0] px_q, ln_q, px_nxt, ln_nxt;
  logic          cnt_en;

  assign run = en && ((px_last != '0) || (ln_last != '0));

  always_comb begin
    px_nxt = px_q;
    ln_nxt = ln_q;
    if (!run) begin
      px_nxt = '0;
      ln_nxt = '0;
    end else if (px_q >= px_last) begin
      px_nxt = '0;
      ln_nxt = (ln_q >= ln_last) ? '0 : ln_q + 1'b1;
    end else begin
      px_nxt = px_q + 1'b1;
    end
  end

  assign cnt_en = run || (px_q != '0) || (ln_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q <= '0;
      ln_q <= '0;
    end else if (cnt_en) begin
      px_q <= px_nxt;
      ln_q <= ln_nxt;
    end
  end

  assign px = px_q;
  assign ln = ln_q;

  // R2
  px_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (px < px_last)) |=> (px == $past(px) + 1'b1));
  // R2
  px_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (px >= px_last)) |=> (px == '0));
  // R2
  ln_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (px >= px_last) && (ln >= ln_last)) |=> (ln == '0));
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((px == '0) && (ln == '0)));
endmodule

// File: rtl/tg_span.sv
module tg_span #(
  parameter int CW    = 12,
  parameter int N     = 1,
  parameter bit USE_Y = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [CW-1:0]        px,
  input  logic [CW-1:0]        ln,
  input  logic [N-1:0][CW-1:0] on_x,
  input  logic [N-1:0][CW-1:0] on_y,
  input  logic [N-1:0][CW-1:0] off_x,
  input  logic [N-1:0][CW-1:0] off_y,
  output logic                 q
);
  logic [N-1:0] on_vec, off_vec;
  logic         on_hit, off_hit, q_q, q_nxt;

  for (genvar i = 0; i < N; i++) begin : g_pair
    assign on_vec[i]  = (px == on_x[i])  && (!USE_Y || (ln == on_y[i]));
    assign off_vec[i] = (px == off_x[i]) && (!USE_Y || (ln == off_y[i]));
  end

  assign on_hit  = |on_vec;
  assign off_hit = |off_vec;

  always_comb begin
    q_nxt = q_q;
    if (!run)        q_nxt = 1'b0;
    else if (off_hit) q_nxt = 1'b0;
    else if (on_hit)  q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_nxt;
  end

  assign q = q_q;

  // R3 R4 R5 R6
  span_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && off_hit) |=> !q);
  // R3 R4 R5 R6
  span_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && on_hit && !off_hit) |=> q);
  // R3 R4 R5 R6
  span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !on_hit && !off_hit) |=> $stable(q));
  // R10
  span_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !q);
endmodule

// File: rtl/tg_field.sv
module tg_field
  import disp_tg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [CW-1:0]             px,
  input  logic [CW-1:0]             ln,
  input  logic [NFIELD-1:0][CW-1:0] fld_x,
  input  logic [NFIELD-1:0][CW-1:0] fld_y,
  input  logic [DONE_W-1:0]         done_clr,
  output logic                      field,
  output logic [DONE_W-1:0]         done
);
  logic [NFIELD-1:0] hit;
  logic              fld_q, fld_nxt;
  logic [DONE_W-1:0] done_q, done_nxt, done_set;

  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    assign hit[f] = run && (px == fld_x[f]) && (ln == fld_y[f]);
  end

  always_comb begin
    fld_nxt = fld_q;
    if (!run)             fld_nxt = 1'b0;
    else if (hit[FLD_ONE]) fld_nxt = 1'b0;
    else if (hit[FLD_TWO]) fld_nxt = 1'b1;
  end

  always_comb begin
    done_set            = '0;
    done_set[DONE_F1]   = hit[FLD_TWO] && !hit[FLD_ONE] && !fld_q;
    done_set[DONE_F2]   = hit[FLD_ONE] && fld_q;
    done_set[DONE_FRM]  = hit[FLD_ONE] && fld_q;
    done_nxt            = done_set | (done_q & ~done_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= 1'b0;
      done_q <= '0;
    end else begin
      fld_q  <= fld_nxt;
      done_q <= done_nxt;
    end
  end

  assign field = fld_q;
  assign done  = done_q;

  // R7
  fld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !field);
  // R8
  f1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[FLD_TWO] && !hit[FLD_ONE] && !field) |=> (field && done[DONE_F1]));
  // R8
  frm_with_f2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[DONE_FRM]) |-> done[DONE_F2]);
  // R9
  f1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr[DONE_F1] && !(hit[FLD_TWO] && !field)) |=> !done[DONE_F1]);
endmodule

// File: rtl/disp_raster_gen.sv
module disp_raster_gen
  import disp_tg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [CW-1:0]             px_last,
  input  logic [CW-1:0]             ln_last,
  input  logic [CW-1:0]             hb_on,
  input  logic [CW-1:0]             hb_off,
  input  logic [CW-1:0]             hs_on,
  input  logic [CW-1:0]             hs_off,
  input  logic [NFIELD-1:0][CW-1:0] vb_on_x,
  input  logic [NFIELD-1:0][CW-1:0] vb_on_y,
  input  logic [NFIELD-1:0][CW-1:0] vb_off_x,
  input  logic [NFIELD-1:0][CW-1:0] vb_off_y,
  input  logic [NFIELD-1:0][CW-1:0] vs_on_x,
  input  logic [NFIELD-1:0][CW-1:0] vs_on_y,
  input  logic [NFIELD-1:0][CW-1:0] vs_off_x,
  input  logic [NFIELD-1:0][CW-1:0] vs_off_y,
  input  logic [NFIELD-1:0][CW-1:0] fld_x,
  input  logic [NFIELD-1:0][CW-1:0] fld_y,
  input  logic [DONE_W-1:0]         done_clr,
  output logic [CW-1:0]             x_pos,
  output logic [CW-1:0]             y_pos,
  output logic                      hblank,
  output logic                      hsync,
  output logic                      vblank,
  output logic                      vsync,
  output logic                      field,
  output logic                      f1_done,
  output logic                      f2_done,
  output logic                      frm_done
);
  logic              run;
  logic [CW-1:0]     px, ln;
  logic [DONE_W-1:0] done;

  tg_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .px_last(px_last), .ln_last(ln_last),
    .run(run), .px(px), .ln(ln)
  );

  tg_span #(.CW(CW), .N(1), .USE_Y(1'b0)) u_hb (
    .clk(clk), .rst_n(rst_n), .run(run), .px(px), .ln(ln),
    .on_x(hb_on), .on_y('0), .off_x(hb_off), .off_y('0), .q(hblank)
  );

  tg_span #(.CW(CW), .N(1), .USE_Y(1'b0)) u_hs (
    .clk(clk), .rst_n(rst_n), .run(run), .px(px), .ln(ln),
    .on_x(hs_on), .on_y('0), .off_x(hs_off), .off_y('0), .q(hsync)
  );

  tg_span #(.CW(CW), .N(NFIELD), .USE_Y(1'b1)) u_vb (
    .clk(clk), .rst_n(rst_n), .run(run), .px(px), .ln(ln),
    .on_x(vb_on_x), .on_y(vb_on_y), .off_x(vb_off_x), .off_y(vb_off_y), .q(vblank)
  );

  tg_span #(.CW(CW), .N(NFIELD), .USE_Y(1'b1)) u_vs (
    .clk(clk), .rst_n(rst_n), .run(run), .px(px), .ln(ln),
    .on_x(vs_on_x), .on_y(vs_on_y), .off_x(vs_off_x), .off_y(vs_off_y), .q(vsync)
  );

  tg_field #(.CW(CW)) u_fld (
    .clk(clk), .rst_n(rst_n), .run(run), .px(px), .ln(ln),
    .fld_x(fld_x), .fld_y(fld_y), .done_clr(done_clr),
    .field(field), .done(done)
  );

  assign x_pos    = px;
  assign y_pos    = ln;
  assign f1_done  = done[DONE_F1];
  assign f2_done  = done[DONE_F2];
  assign frm_done = done[DONE_FRM];

  // R11
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((px_last == '0) && (ln_last == '0)) |=> (!hblank && !hsync && !vblank && !vsync));
endmodule

// File: tb/tb_disp_raster_gen.sv
module tb_disp_raster_gen;
  localparam int CW = 12;

  typedef struct packed {
    logic [CW-1:0] px;
    logic [CW-1:0] ln;
    logic hb, hs, vb, vs, fld, d1, d2, df;
  } exp_t;

  logic clk, rst_n, en;
  logic [CW-1:0] px_last, ln_last, hb_on, hb_off, hs_on, hs_off;
  logic [1:0][CW-1:0] vb_on_x, vb_on_y, vb_off_x, vb_off_y;
  logic [1:0][CW-1:0] vs_on_x, vs_on_y, vs_off_x, vs_off_y, fld_x, fld_y;
  logic [2:0] done_clr;
  logic [CW-1:0] x_pos, y_pos;
  logic hblank, hsync, vblank, vsync, field, f1_done, f2_done, frm_done;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  exp_t exp_q[$];

  disp_raster_gen #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .px_last(px_last), .ln_last(ln_last),
    .hb_on(hb_on), .hb_off(hb_off), .hs_on(hs_on), .hs_off(hs_off),
    .vb_on_x(vb_on_x), .vb_on_y(vb_on_y), .vb_off_x(vb_off_x), .vb_off_y(vb_off_y),
    .vs_on_x(vs_on_x), .vs_on_y(vs_on_y), .vs_off_x(vs_off_x), .vs_off_y(vs_off_y),
    .fld_x(fld_x), .fld_y(fld_y), .done_clr(done_clr),
    .x_pos(x_pos), .y_pos(y_pos), .hblank(hblank), .hsync(hsync),
    .vblank(vblank), .vsync(vsync), .field(field),
    .f1_done(f1_done), .f2_done(f2_done), .frm_done(frm_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string what, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic nxt_span(logic q, logic run, logic on, logic off);
    if (!run) return 1'b0;
    if (off) return 1'b0;
    if (on) return 1'b1;
    return q;
  endfunction

  exp_t m, n;
  logic m_run, h1, h2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = '0;
    end else begin
      n = m;
      m_run = en && (px_last != 0 || ln_last != 0);
      // R3 / R4: pixel-only compares
      n.hb = nxt_span(m.hb, m_run, m.px == hb_on, m.px == hb_off);
      n.hs = nxt_span(m.hs, m_run, m.px == hs_on, m.px == hs_off);
      // R5 / R6: either field's pair
      n.vb = nxt_span(m.vb, m_run,
        (m.ln == vb_on_y[0] && m.px == vb_on_x[0]) || (m.ln == vb_on_y[1] && m.px == vb_on_x[1]),
        (m.ln == vb_off_y[0] && m.px == vb_off_x[0]) || (m.ln == vb_off_y[1] && m.px == vb_off_x[1]));
      n.vs = nxt_span(m.vs, m_run,
        (m.ln == vs_on_y[0] && m.px == vs_on_x[0]) || (m.ln == vs_on_y[1] && m.px == vs_on_x[1]),
        (m.ln == vs_off_y[0] && m.px == vs_off_x[0]) || (m.ln == vs_off_y[1] && m.px == vs_off_x[1]));
      // R7 / R8 / R9
      h1 = m_run && m.ln == fld_y[0] && m.px == fld_x[0];
      h2 = m_run && m.ln == fld_y[1] && m.px == fld_x[1];
      n.d1 = (h2 && !h1 && !m.fld) || (m.d1 && !done_clr[0]);
      n.d2 = (h1 && m.fld) || (m.d2 && !done_clr[1]);
      n.df = (h1 && m.fld) || (m.df && !done_clr[2]);
      if (!m_run) n.fld = 1'b0;
      else if (h1) n.fld = 1'b0;
      else if (h2) n.fld = 1'b1;
      // R2 / R10 / R11
      if (!m_run) begin
        n.px = 0; n.ln = 0;
      end else if (m.px >= px_last) begin
        n.px = 0;
        n.ln = (m.ln >= ln_last) ? 0 : m.ln + 1;
      end else begin
        n.px = m.px + 1;
      end
      m = n;
      exp_q.push_back(n);
    end
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R2 x_pos", x_pos, e.px);
      chk("R2 y_pos", y_pos, e.ln);
      chk("R3 hblank", {11'd0, hblank}, {11'd0, e.hb});
      chk("R4 hsync", {11'd0, hsync}, {11'd0, e.hs});
      chk("R5 vblank", {11'd0, vblank}, {11'd0, e.vb});
      chk("R6 vsync", {11'd0, vsync}, {11'd0, e.vs});
      chk("R7 field", {11'd0, field}, {11'd0, e.fld});
      chk("R8/R9 f1_done", {11'd0, f1_done}, {11'd0, e.d1});
      chk("R8/R9 f2_done", {11'd0, f2_done}, {11'd0, e.d2});
      chk("R8/R9 frm_done", {11'd0, frm_done}, {11'd0, e.df});
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_cyc(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic cfg_a();
    px_last = 19; ln_last = 9;
    hb_on = 15; hb_off = 0; hs_on = 16; hs_off = 18;
    vb_on_y[0] = 3; vb_on_x[0] = 0;  vb_off_y[0] = 4; vb_off_x[0] = 10;
    vb_on_y[1] = 8; vb_on_x[1] = 10; vb_off_y[1] = 9; vb_off_x[1] = 0;
    vs_on_y[0] = 3; vs_on_x[0] = 5;  vs_off_y[0] = 3; vs_off_x[0] = 15;
    vs_on_y[1] = 8; vs_on_x[1] = 15; vs_off_y[1] = 9; vs_off_x[1] = 5;
    fld_y[0] = 0; fld_x[0] = 0; fld_y[1] = 4; fld_x[1] = 10;
  endtask

  task automatic cfg_b();
    px_last = 11; ln_last = 5;
    hb_on = 8; hb_off = 2; hs_on = 3; hs_off = 3;
    vb_on_y[0] = 2; vb_on_x[0] = 6; vb_off_y[0] = 3; vb_off_x[0] = 0;
    vb_on_y[1] = 5; vb_on_x[1] = 0; vb_off_y[1] = 0; vb_off_x[1] = 6;
    vs_on_y[0] = 2; vs_on_x[0] = 6; vs_off_y[0] = 2; vs_off_x[0] = 6;
    vs_on_y[1] = 5; vs_on_x[1] = 3; vs_off_y[1] = 5; vs_off_x[1] = 9;
    fld_y[0] = 0; fld_x[0] = 6; fld_y[1] = 3; fld_x[1] = 0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; done_clr = '0;
    cfg_a();
    wait_cyc(3);
    // R1: reset state
    chk("R1 x_pos", x_pos, 0);
    chk("R1 y_pos", y_pos, 0);
    chk("R1 syncs", {8'd0, hblank, hsync, vblank, vsync}, 0);
    chk("R1 field", {11'd0, field}, 0);
    chk("R1 done", {9'd0, f1_done, f2_done, frm_done}, 0);
    rst_n = 1'b1;
    en = 1'b1;
    wait_cyc(450);
    // R8: two frames passed, all done flags set
    chk("R8 done after two frames", {9'd0, f1_done, f2_done, frm_done}, 3'b111);
    // R9: clear field-1 flag only
    done_clr = 3'b001;
    wait_cyc(1);
    done_clr = 3'b000;
    chk("R9 f1 cleared", {11'd0, f1_done}, 0);
    chk("R9 f2 kept", {11'd0, f2_done}, 1);
    done_clr = 3'b110;
    wait_cyc(1);
    done_clr = 3'b000;
    chk("R9 f2/frm cleared", {10'd0, f2_done, frm_done}, 0);
    wait_cyc(37);
    // R10: enable drop in mid-frame
    en = 1'b0;
    wait_cyc(2);
    chk("R10 x_pos idle", x_pos, 0);
    chk("R10 y_pos idle", y_pos, 0);
    chk("R10 outputs idle", {7'd0, hblank, hsync, vblank, vsync, field}, 0);
    wait_cyc(20);
    cfg_b();
    wait_cyc(2);
    en = 1'b1;
    wait_cyc(250);
    en = 1'b0;
    wait_cyc(3);
    // R11: zero frame size
    px_last = 0; ln_last = 0;
    en = 1'b1;
    wait_cyc(40);
    chk("R11 x_pos zero", x_pos, 0);
    chk("R11 y_pos zero", y_pos, 0);
    chk("R11 no events", {7'd0, hblank, hsync, vblank, vsync, field}, 0);
    wait_cyc(2);
    finished = 1;
    summary();
    $finish;
  end
endmodule